// File: doc/BRIEF.md
# Registered Sum-of-Products Output Array

This block is a small programmable logic fabric built around sum-of-products terms. A programmable AND plane forms product terms from the external inputs and from values fed back by the output cells. The OR side is fixed: every output cell owns a fixed, private group of product terms and takes their logical OR.

Each output cell can present that OR result directly, or the value a D flip-flop captured from it at the last rising clock edge. Each cell also has an output-enable flag, which models a tri-state pin. Each cell's flip-flop value goes back into the AND plane as an extra variable, so registered cells can be combined into state machines.

The connection bits of the AND plane, and each cell's mode (registered select and output enable), are written through a simple configuration port one word per cycle. At reset, nothing is connected. Every cell starts in combinational mode with its output disabled.

Top module: `pal_macro_array`

## Requirements
- R1: After reset every cell flip-flop holds 0, every cell is combinational with its enable low, every connection bit is clear, and so `dout` and `dout_oe` are all zero.
- R2: A connection bit at 1 includes its literal in the product term. A term is the AND of its connected literals, and a term with no connected literal is 0.
- R3: Literal `2*v` is the true form and literal `2*v+1` the complement of variable `v`. Variables `0..N_IN-1` are `din`, and variable `N_IN+m` is the feedback of cell `m`.
- R4: Cell `m` ORs exactly product terms `m*PT_PER` to `m*PT_PER+PT_PER-1`. Terms of other cells never reach it.
- R5: A cell in combinational mode shows its OR result on `dout` in the same cycle as the inputs.
- R6: A cell in registered mode shows on `dout` the OR result sampled at the previous rising clock edge.
- R7: The feedback variable of cell `m` is its flip-flop value in both modes. A registered cell whose only term is its own complemented feedback therefore toggles every cycle.
- R8: `dout_oe[m]` equals the enable bit of cell `m` and changes only on a mode write. The enable has no effect on `dout` or on the feedback.
- R9: A write with `cfg_kind`=0 loads `cfg_data` as the connection row of term `cfg_addr`. A write with `cfg_kind`=1 loads cell `cfg_addr`: `cfg_data[0]` selects registered mode and `cfg_data[1]` is the enable. Either write takes effect from the next cycle.
- R10: A mode write whose address is `N_MC` or more changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for cell flip-flops and configuration |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N_IN | External input variables |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = connection row, 1 = cell mode |
| cfg_addr | input | clog2(N_MC*PT_PER) | Term index or cell index |
| cfg_data | input | 2*(N_IN+N_MC) | Connection row, or mode bits in [1:0] |
| dout | output | N_MC | Selected value of each cell |
| dout_oe | output | N_MC | Output enable of each cell (0 = high impedance) |

## Verification
Single-literal terms in both polarities separate the true and complemented literal numbering. An all-clear term, with every input driven high, shows that an unprogrammed term gives 0 rather than 1. A term programmed for one cell while the others are probed shows that the OR groups are private to each cell.

A self-inverting registered cell and a combinational cell that holds its own output through feedback tell the two select paths apart, and show that feedback is taken from the flip-flop. Random connection rows, random modes and random inputs then run against a cycle model of the array, which exposes errors in literal order, term grouping and one-cycle timing.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    CFG_FUSE = 1'b0,
    CFG_MODE = 1'b1
  } cfg_kind_e;

  typedef struct packed {
    logic oe;
    logic reg_sel;
  } mc_mode_t;
endpackage

// File: rtl/pal_term_array.sv
module pal_term_array #(
  parameter int N_VAR = 12,
  parameter int N_PT  = 16,
  localparam int LIT_W = 2 * N_VAR
) (
  input  logic [N_VAR-1:0]            vars,
  input  logic [N_PT-1:0][LIT_W-1:0]  fuses,
  output logic [N_PT-1:0]             pt
);
  logic [LIT_W-1:0] lit;

  for (genvar v = 0; v < N_VAR; v++) begin : g_lit
    assign lit[2*v]   = vars[v];
    assign lit[2*v+1] = ~vars[v];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = (|fuses[t]) & (&(~fuses[t] | lit));
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int PT_PER = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PT_PER-1:0] pt_grp,
  input  mc_mode_t          mode,
  output logic              pin_data,
  output logic              pin_oe,
  output logic              fb_q
);
  logic or_val;
  logic q_d;
  logic q_r;
  logic seen_clk;

  always_comb begin
    or_val = |pt_grp;
    q_d    = or_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else begin
      q_r <= q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  assign pin_data = mode.reg_sel ? q_r : or_val;
  assign pin_oe   = mode.oe;
  assign fb_q     = q_r;

  // R6: registered path shows the OR value of the previous edge
  a_r6_reg_path: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && mode.reg_sel) |-> (pin_data == $past(or_val)));
endmodule

// File: rtl/pal_macro_array.sv
module pal_macro_array
  import pal_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_MC   = 4,
  parameter int PT_PER = 4,
  localparam int N_VAR = N_IN + N_MC,
  localparam int LIT_W = 2 * N_VAR,
  localparam int N_PT  = N_MC * PT_PER,
  localparam int AW    = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  din,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [LIT_W-1:0] cfg_data,
  output logic [N_MC-1:0]  dout,
  output logic [N_MC-1:0]  dout_oe
);
  logic [N_PT-1:0][LIT_W-1:0] fuse_q, fuse_d;
  mc_mode_t [N_MC-1:0]        mode_q, mode_d;
  logic [N_PT-1:0]            fuse_wr;
  logic [N_MC-1:0]            mode_wr;
  logic [N_MC-1:0]            fb;
  logic [N_VAR-1:0]           vars;
  logic [N_PT-1:0]            pt;

  // configuration write decode and next state
  always_comb begin
    fuse_d = fuse_q;
    mode_d = mode_q;
    for (int t = 0; t < N_PT; t++) begin
      fuse_wr[t] = cfg_we && (cfg_kind == CFG_FUSE) && (cfg_addr == AW'(t));
      if (fuse_wr[t]) fuse_d[t] = cfg_data;
    end
    for (int m = 0; m < N_MC; m++) begin
      mode_wr[m] = cfg_we && (cfg_kind == CFG_MODE) && (cfg_addr == AW'(m));
      if (mode_wr[m]) begin
        mode_d[m].reg_sel = cfg_data[0];
        mode_d[m].oe      = cfg_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_q <= '0;
      mode_q <= '0;
    end else begin
      fuse_q <= fuse_d;
      mode_q <= mode_d;
    end
  end

  assign vars = {fb, din};

  pal_term_array #(.N_VAR(N_VAR), .N_PT(N_PT)) u_terms (
    .vars  (vars),
    .fuses (fuse_q),
    .pt    (pt)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    pal_macrocell #(.PT_PER(PT_PER)) u_mc (
      .clk      (clk),
      .rst_n    (rst_n),
      .pt_grp   (pt[m*PT_PER +: PT_PER]),
      .mode     (mode_q[m]),
      .pin_data (dout[m]),
      .pin_oe   (dout_oe[m]),
      .fb_q     (fb[m])
    );

    // R9: mode write lands on the enable port one cycle later
    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_kind == CFG_MODE && int'(cfg_addr) == m)
      |=> (dout_oe[m] == $past(cfg_data[1])));
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_chk
    // R2: a term with no connected literal stays low
    a_r2_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_q[t] == '0) |-> (pt[t] == 1'b0));
  end

  // R8: enables move only on a mode write
  a_r8_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_kind == CFG_MODE) |=> $stable(dout_oe));

  // R10: out-of-range mode address leaves every cell alone
  a_r10_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == CFG_MODE && int'(cfg_addr) >= N_MC)
    |=> $stable(dout_oe));
endmodule

// File: tb/tb_pal_macro_array.sv
module tb_pal_macro_array;
  localparam int N_IN   = 8;
  localparam int N_MC   = 4;
  localparam int PT_PER = 4;
  localparam int N_VAR  = N_IN + N_MC;
  localparam int LIT_W  = 2 * N_VAR;
  localparam int N_PT   = N_MC * PT_PER;
  localparam int AW     = $clog2(N_PT);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_IN-1:0]  din = '0;
  logic             cfg_we = 1'b0;
  logic             cfg_kind = 1'b0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [LIT_W-1:0] cfg_data = '0;
  logic [N_MC-1:0]  dout;
  logic [N_MC-1:0]  dout_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [LIT_W-1:0] m_fuse [N_PT];
  logic [N_MC-1:0]  m_sel, m_oe, m_q;

  always #2 clk = ~clk;

  pal_macro_array #(.N_IN(N_IN), .N_MC(N_MC), .PT_PER(PT_PER)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [N_MC-1:0] f_or();
    logic [N_VAR-1:0] v;
    logic [LIT_W-1:0] l;
    logic [N_MC-1:0]  r;
    v = {m_q, din};
    for (int i = 0; i < N_VAR; i++) begin
      l[2*i] = v[i];
      l[2*i+1] = ~v[i];
    end
    r = '0;
    for (int t = 0; t < N_PT; t++) begin
      logic term;
      term = (m_fuse[t] != '0);
      for (int b = 0; b < LIT_W; b++)
        if (m_fuse[t][b] && !l[b]) term = 1'b0;
      if (term) r[t / PT_PER] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [N_MC-1:0] f_data();
    logic [N_MC-1:0] o;
    o = f_or();
    return (m_sel & m_q) | (~m_sel & o);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < N_PT; t++) m_fuse[t] <= '0;
      m_sel <= '0;
      m_oe  <= '0;
      m_q   <= '0;
    end else begin
      m_q <= f_or();
      if (cfg_we && cfg_kind == 1'b0) m_fuse[cfg_addr] <= cfg_data;
      if (cfg_we && cfg_kind == 1'b1 && int'(cfg_addr) < N_MC) begin
        m_sel[cfg_addr] <= cfg_data[0];
        m_oe[cfg_addr]  <= cfg_data[1];
      end
    end
  end

  task automatic check(string req);
    logic [N_MC-1:0] ed, eo;
    ed = f_data();
    eo = m_oe;
    n_chk++;
    if (dout !== ed || dout_oe !== eo) begin
      n_bad++;
      $display("FAIL %s: dout=%b oe=%b expected dout=%b oe=%b", req, dout, dout_oe, ed, eo);
    end
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(logic kind, int addr, logic [LIT_W-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_addr = AW'(addr); cfg_data = data;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic drive(logic [N_IN-1:0] d, string req);
    @(negedge clk);
    din = d;
    #1 check(req);
  endtask

  task automatic clear_all();
    for (int t = 0; t < N_PT; t++) wr(1'b0, t, '0);
    for (int m = 0; m < N_MC; m++) wr(1'b1, m, '0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic prev;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    expect_bit("R1 dout", |dout, 1'b0);
    expect_bit("R1 oe", |dout_oe, 1'b0);
    check("R1");

    // R2: all terms clear, all inputs high gives 0
    drive('1, "R2 empty term");
    expect_bit("R2 empty", dout[0], 1'b0);

    // R3/R5: term0 = din0 & ~din1 (literals 0 and 3)
    wr(1'b0, 0, LIT_W'(24'h000009));
    drive(8'b0000_0001, "R3");
    expect_bit("R3 true/compl", dout[0], 1'b1);
    drive(8'b0000_0011, "R3");
    expect_bit("R3 complement kills", dout[0], 1'b0);
    drive(8'b0000_0000, "R5");
    expect_bit("R5 comb low", dout[0], 1'b0);

    // R4: term 4 (cell 1) = din7; cell 0 and cell 2 unaffected
    wr(1'b0, 4, LIT_W'(1) << 14);
    drive(8'b1000_0000, "R4");
    expect_bit("R4 own group", dout[1], 1'b1);
    expect_bit("R4 other cell", dout[2], 1'b0);
    expect_bit("R4 other cell0", dout[0], 1'b0);

    // R8: enable without data change
    wr(1'b1, 2, LIT_W'(2'b10));
    drive(8'b1000_0000, "R8");
    expect_bit("R8 oe set", dout_oe[2], 1'b1);
    expect_bit("R8 data untouched", dout[2], 1'b0);

    // R10: bad mode address
    wr(1'b1, N_MC + 1, LIT_W'(2'b11));
    drive(8'b1000_0000, "R10");
    expect_bit("R10 oe3", dout_oe[3], 1'b0);
    expect_bit("R10 oe0", dout_oe[0], 1'b0);

    // R6/R7: cell 0 registered, only term = ~fb0 (literal 2*N_IN+1)
    clear_all();
    wr(1'b0, 0, LIT_W'(1) << (2*N_IN + 1));
    wr(1'b1, 0, LIT_W'(2'b01));
    drive('0, "R6");
    prev = dout[0];
    for (int k = 0; k < 6; k++) begin
      drive('0, "R7 toggle");
      expect_bit("R7 toggles", dout[0], ~prev);
      prev = dout[0];
    end

    // R7: comb cell 1 holds via feedback (term4 = fb1, term5 = din0)
    clear_all();
    wr(1'b0, 4, LIT_W'(1) << (2*(N_IN+1)));
    wr(1'b0, 5, LIT_W'(1));
    drive(8'h01, "R7 set");
    expect_bit("R7 comb set", dout[1], 1'b1);
    drive(8'h00, "R7 hold");
    expect_bit("R7 comb hold", dout[1], 1'b1);

    // R9 + random: random rows and modes, random inputs
    for (int blk = 0; blk < 40; blk++) begin
      for (int r = 0; r < 4; r++) begin
        int t;
        logic [LIT_W-1:0] f;
        t = int'($urandom_range(N_PT - 1));
        f = LIT_W'($urandom & $urandom & $urandom & $urandom);
        wr(1'b0, t, f);
      end
      wr(1'b1, int'($urandom_range(N_MC - 1)), LIT_W'($urandom_range(3)));
      #1 check("R9 write");
      for (int c = 0; c < 40; c++)
        drive(N_IN'($urandom), "R6 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule